// File: doc/BRIEF.md
# SMBus Slave Interface with Alert Response

This block is the host-facing serial port of a register-based peripheral controller. It watches the two-wire bus through a clock input and a data input, and answers through a separate data output that can only pull the line low. Because input and output are kept apart, a board can short them together into an ordinary open-drain data pin, or route each through its own isolator. Both bus lines are brought into the system clock domain through a short synchroniser chain. START, STOP and SCL edges are recognised from the synchronised levels.

The slave answers three addresses. The first is its own address, built from fixed high bits and four strap inputs. The second is a shared broadcast address that a host uses to write the same value into every controller on the bus at once. The third is the alert response address, which the slave answers only while its interrupt is active. A Write Byte transfer selects one register of a small internal file and writes it. A Read Byte transfer selects a register and then reads it back after a repeated START. A Receive Byte transfer reads whichever register was selected last. A Receive Byte to the alert response address instead returns the slave's own address. The interrupt output follows a request from the peripheral logic, but it may only change while the bus is between transactions.

Top module: `smb_alert_slave`

## Requirements
- R1: The slave acknowledges the 7-bit address {0,1,0,A3,A2,A1,A0}, where A3..A0 is `addr_strap`, for both read and write. It leaves every address other than those of R5 and R6 unacknowledged, and a strap change takes effect for the next transfer.
- R2: In a write, the byte after the address is a command. Its low log2(NREG) bits select a register and its upper bits are ignored. The next byte is stored in that register, which appears on `regs_o[8*i+7:8*i]` for register i. A transfer the slave did not acknowledge leaves every register unchanged.
- R3: A Read Byte transfer returns the register named by the command, most significant bit first. The transfer is: START, address with write, command, repeated START, address with read, then one data byte.
- R4: A Receive Byte transfer to the own address returns the register selected by the most recent command byte.
- R5: The broadcast address 0110000 is acknowledged with the write bit and stores data exactly like R2. With the read bit it is not acknowledged.
- R6: The alert response address 0001100 with the read bit is acknowledged only while `int_n` is low. The returned byte is the own 7-bit address followed by a 0 in bit 0.
- R7: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A repeated START restarts the address phase the same way a first START does, discarding any unfinished transfer.
- R8: `int_n` is driven low while the latched request is set. The latch copies `irq_req` only while no transaction is open, which is from reset or a STOP until the next START. While a transaction is open, `int_n` holds its value.
- R9: A START seen after reset with no STOP after it keeps `int_n` high, even if a request is raised. The request becomes visible only once a STOP has been seen.
- R10: `sda_pull` is high only for an acknowledge bit or for a 0 data bit sent by the slave. It changes only while SCL is low, except that a STOP releases it. It stays low whenever the bus is idle.
- R11: After reset, `int_n` is high, `sda_pull` is low and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_strap | input | 4 | Low four bits of the own bus address |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 = pull the data line low, 0 = release it |
| irq_req | input | 1 | Interrupt request from the peripheral logic |
| int_n | output | 1 | Active-low interrupt, 0 = asserted |
| regs_o | output | NREG*8 | Contents of the register file, register i at bits 8*i+7:8*i |

## Verification
The assertions rely on some assumptions about the bus. Every high and every low phase of SCL is assumed to last several system clocks, so each level passes through the synchroniser and stays visible for at least two cycles after an edge is detected. SDA is assumed to change while SCL is high only to form a START or a STOP. The bench keeps within these limits: it holds every bus-line level for six clocks, changes SDA only while SCL is low, and keeps the strap and request inputs still during a transfer. The one exception is the deliberate request change in the interrupt-freeze test.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int BYTE_W = 8;
  localparam logic [2:0] OWN_ADDR_HI = 3'b010;
  localparam logic [6:0] BCAST_ADDR  = 7'b0110000;
  localparam logic [6:0] ALERT_ADDR  = 7'b0001100;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_CMD,
    S_CMD_ACK,
    S_WDAT,
    S_WDAT_ACK,
    S_TX,
    S_TX_ACK,
    S_HOLD
  } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_d
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '1;
      q_d     <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d};
      q_d     <= chain_q[STAGES-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_pkg::*;
#(
  parameter int NREG = 4,
  localparam int PW = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [PW-1:0]          waddr,
  input  logic [BYTE_W-1:0]      wdata,
  input  logic [PW-1:0]          raddr,
  output logic [BYTE_W-1:0]      rdata,
  output logic [NREG*BYTE_W-1:0] flat
);
  logic [BYTE_W-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[g] <= '0;
      end else if (we && (waddr == PW'(g))) begin
        mem[g] <= wdata;
      end
    end
    assign flat[g*BYTE_W +: BYTE_W] = mem[g];
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/smb_irq_hold.sv
module smb_irq_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_start,
  input  logic bus_stop,
  input  logic irq_req,
  output logic busy,
  output logic int_act
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (bus_start) begin
      busy <= 1'b1;
    end else if (bus_stop) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_act <= 1'b0;
    end else if (!busy && !bus_start) begin
      int_act <= irq_req;
    end
  end

  // R8: no interrupt change while a transaction is open
  p_int_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(int_act));

  // R9: a START always opens the hold window
  p_busy_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> busy);
endmodule

// File: rtl/smb_alert_slave.sv
module smb_alert_slave
  import smb_pkg::*;
#(
  parameter int NREG        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [3:0]             addr_strap,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_pull,
  input  logic                   irq_req,
  output logic                   int_n,
  output logic [NREG*BYTE_W-1:0] regs_o
);
  localparam int PW    = $clog2(NREG);
  localparam int NLINE = 2;

  // line synchronisers: index 0 = clock line, index 1 = data line
  logic [NLINE-1:0] raw_l, lvl_l, lvl_d;
  assign raw_l = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_sync
    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_l[g]),
      .q    (lvl_l[g]),
      .q_d  (lvl_d[g])
    );
  end

  logic scl_s, scl_d, sda_s, sda_d;
  assign scl_s = lvl_l[0];
  assign scl_d = lvl_d[0];
  assign sda_s = lvl_l[1];
  assign sda_d = lvl_d[1];

  logic bus_start, bus_stop, scl_rise, scl_fall;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;

  // state
  smb_state_e        state_q;
  logic [3:0]        bit_cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] tx_q;
  logic              drive_q;
  logic              rd_q;
  logic [PW-1:0]     ptr_q;

  logic              txn_busy, int_act;
  logic [BYTE_W-1:0] rdata;

  // address decode of the byte just shifted in
  logic [6:0] rx_addr, own_addr;
  logic       rx_rw, hit_own, hit_bc, hit_alert, addr_hit, byte_end, wr_en;

  assign rx_addr   = sh_q[7:1];
  assign rx_rw     = sh_q[0];
  assign own_addr  = {OWN_ADDR_HI, addr_strap};
  assign hit_own   = (rx_addr == own_addr);
  assign hit_bc    = (rx_addr == BCAST_ADDR) && !rx_rw;
  assign hit_alert = (rx_addr == ALERT_ADDR) && rx_rw && int_act;
  assign addr_hit  = hit_own | hit_bc | hit_alert;
  assign byte_end  = scl_fall && (bit_cnt_q == 4'd8);
  assign wr_en     = (state_q == S_WDAT) && byte_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      drive_q   <= 1'b0;
      rd_q      <= 1'b0;
      ptr_q     <= '0;
    end else if (bus_start) begin
      state_q   <= S_ADDR;
      bit_cnt_q <= '0;
      drive_q   <= 1'b0;
    end else if (bus_stop) begin
      state_q   <= S_IDLE;
      drive_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_ADDR, S_CMD, S_WDAT: begin
          if (scl_rise) begin
            sh_q      <= {sh_q[BYTE_W-2:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_end) begin
            bit_cnt_q <= '0;
            if (state_q == S_ADDR) begin
              if (addr_hit) begin
                drive_q <= 1'b1;
                rd_q    <= rx_rw;
                tx_q    <= hit_alert ? {own_addr, 1'b0} : rdata;
                state_q <= S_ADDR_ACK;
              end else begin
                state_q <= S_HOLD;
              end
            end else if (state_q == S_CMD) begin
              ptr_q   <= sh_q[PW-1:0];
              drive_q <= 1'b1;
              state_q <= S_CMD_ACK;
            end else begin
              drive_q <= 1'b1;
              state_q <= S_WDAT_ACK;
            end
          end
        end
        S_ADDR_ACK: begin
          if (scl_fall) begin
            bit_cnt_q <= '0;
            if (rd_q) begin
              drive_q <= ~tx_q[BYTE_W-1];
              state_q <= S_TX;
            end else begin
              drive_q <= 1'b0;
              state_q <= S_CMD;
            end
          end
        end
        S_CMD_ACK: begin
          if (scl_fall) begin
            drive_q <= 1'b0;
            state_q <= S_WDAT;
          end
        end
        S_WDAT_ACK: begin
          if (scl_fall) begin
            drive_q <= 1'b0;
            state_q <= S_HOLD;
          end
        end
        S_TX: begin
          if (scl_rise) begin
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt_q == 4'd8) begin
              drive_q <= 1'b0;
              state_q <= S_TX_ACK;
            end else begin
              tx_q    <= {tx_q[BYTE_W-2:0], 1'b0};
              drive_q <= ~tx_q[BYTE_W-2];
            end
          end
        end
        S_TX_ACK: begin
          if (scl_fall) state_q <= S_HOLD;
        end
        default: ;
      endcase
    end
  end

  smb_regfile #(.NREG(NREG)) u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_en),
    .waddr(ptr_q),
    .wdata(sh_q),
    .raddr(ptr_q),
    .rdata(rdata),
    .flat (regs_o)
  );

  smb_irq_hold u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_start(bus_start),
    .bus_stop (bus_stop),
    .irq_req  (irq_req),
    .busy     (txn_busy),
    .int_act  (int_act)
  );

  assign sda_pull = drive_q;
  assign int_n    = ~int_act;

  // R7: START always restarts the address phase
  p_start_to_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (state_q == S_ADDR));

  // R10: STOP releases the data line
  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !sda_pull);

  // R10: data line moves only while the clock line is low
  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_pull != $past(sda_pull)) && !$past(bus_stop) && !$past(bus_start)) |-> !scl_s);

  // R6: alert address is refused while no interrupt is pending
  p_alert_needs_int_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_ADDR) && byte_end && (rx_addr == ALERT_ADDR) && rx_rw && !int_act)
      |=> (state_q == S_HOLD));

  // R2: register writes happen only inside an open transaction
  p_write_in_txn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> txn_busy);
endmodule

// File: tb/test_smb_alert_slave.sv
module test_smb_alert_slave;
  localparam int NREG = 4;
  localparam int H    = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [3:0]  strap;
  logic        bm_scl, bm_sda, irq_req;
  logic        sda_pull, int_n;
  logic [31:0] regs;
  logic        sda_line;

  assign sda_line = bm_sda & ~sda_pull;

  smb_alert_slave #(.NREG(NREG)) i_smb_alert_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_strap(strap),
    .scl_i     (bm_scl),
    .sda_i     (sda_line),
    .sda_pull  (sda_pull),
    .irq_req   (irq_req),
    .int_n     (int_n),
    .regs_o    (regs)
  );

  int nchk = 0, nfail = 0;
  int cyc = 0, last_evt = 0;
  logic model_busy = 1'b0, model_int = 1'b0;
  logic [7:0] mregs [NREG];
  bit done = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] flat_model();
    logic [31:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = mregs[i];
    return f;
  endfunction

  // cycle-by-cycle reference comparison
  always @(posedge clk) begin
    #1;
    if (rst_n === 1'b1 && !done && (cyc - last_evt) > 5) begin
      if (!model_busy) model_int = irq_req;
      chk("R8 int_n per clock", {31'd0, int_n}, {31'd0, ~model_int});
      if (!model_busy) begin
        chk("R10 sda_pull idle", {31'd0, sda_pull}, 32'd0);
        chk("R2 regs_o model", regs, flat_model());
      end
    end
  end

  task automatic drive_bus(input logic s, input logic d);
    bm_scl   = s;
    bm_sda   = d;
    last_evt = cyc;
    repeat (H) @(negedge clk);
  endtask

  task automatic start_cond();
    drive_bus(bm_scl, 1'b1);
    drive_bus(1'b1, 1'b1);
    model_busy = 1'b1;
    drive_bus(1'b1, 1'b0);
    drive_bus(1'b0, 1'b0);
  endtask

  task automatic stop_cond();
    drive_bus(1'b0, 1'b0);
    drive_bus(1'b1, 1'b0);
    model_busy = 1'b0;
    drive_bus(1'b1, 1'b1);
  endtask

  task automatic clock_bit(input logic b, output logic r);
    drive_bus(1'b0, b);
    drive_bus(1'b1, b);
    r = sda_line;
    drive_bus(1'b0, b);
  endtask

  task automatic write_byte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(v[i], r);
    clock_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic read_byte(output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, r);
      v[i] = r;
    end
    clock_bit(1'b1, r);
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d,
                        output logic [2:0] acks);
    acks = 3'b000;
    start_cond();
    write_byte({a, 1'b0}, acks[2]);
    if (acks[2]) begin
      write_byte(cmd, acks[1]);
      write_byte(d, acks[0]);
      if (acks == 3'b111) mregs[cmd[1:0]] = d;
    end
    stop_cond();
  endtask

  task automatic rd_txn(input logic [6:0] a, input logic [7:0] cmd,
                        output logic [7:0] v, output logic [2:0] acks);
    acks = 3'b000;
    v = 8'hxx;
    start_cond();
    write_byte({a, 1'b0}, acks[2]);
    if (acks[2]) begin
      write_byte(cmd, acks[1]);
      start_cond();
      write_byte({a, 1'b1}, acks[0]);
      if (acks[0]) read_byte(v);
    end
    stop_cond();
  endtask

  task automatic rx_txn(input logic [6:0] a, output logic [7:0] v, output logic ack);
    v = 8'hxx;
    start_cond();
    write_byte({a, 1'b1}, ack);
    if (ack) read_byte(v);
    stop_cond();
  endtask

  task automatic finish_up();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] v;
    logic       ack;
    for (int i = 0; i < NREG; i++) mregs[i] = 8'h00;
    rst_n = 1'b0; strap = 4'b0101; bm_scl = 1'b1; bm_sda = 1'b1; irq_req = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    last_evt = cyc;
    repeat (3) @(negedge clk);
    chk("R11 reset int_n", {31'd0, int_n}, 32'd1);
    chk("R11 reset sda_pull", {31'd0, sda_pull}, 32'd0);
    chk("R11 reset regs", regs, 32'd0);

    // R9: START right after reset, request raised, no STOP yet
    model_busy = 1'b1;
    drive_bus(1'b1, 1'b0);
    irq_req = 1'b1;
    last_evt = cyc;
    repeat (20) @(negedge clk);
    chk("R9 int held before stop", {31'd0, int_n}, 32'd1);
    stop_cond();
    repeat (8) @(negedge clk);
    chk("R9 int after stop", {31'd0, int_n}, 32'd0);
    irq_req = 1'b0;
    last_evt = cyc;
    repeat (8) @(negedge clk);

    // R1/R2: Write Byte to own address
    wr_txn(7'h25, 8'h02, 8'hA5, acks);
    chk("R1 write acks", {29'd0, acks}, 32'd7);
    repeat (8) @(negedge clk);
    chk("R2 reg2 written", {24'd0, regs[23:16]}, 32'hA5);
    wr_txn(7'h25, 8'h81, 8'h3C, acks);
    chk("R2 upper cmd bits ignored acks", {29'd0, acks}, 32'd7);
    repeat (8) @(negedge clk);
    chk("R2 reg1 via cmd 81", {24'd0, regs[15:8]}, 32'h3C);

    // R3: Read Byte
    rd_txn(7'h25, 8'h02, v, acks);
    chk("R3 read acks", {29'd0, acks}, 32'd7);
    chk("R3 read reg2", {24'd0, v}, 32'hA5);
    rd_txn(7'h25, 8'h85, v, acks);
    chk("R3 read reg1 via cmd 85", {24'd0, v}, 32'h3C);

    // R4: Receive Byte returns last selected register
    rx_txn(7'h25, v, ack);
    chk("R4 receive ack", {31'd0, ack}, 32'd1);
    chk("R4 receive reg1", {24'd0, v}, 32'h3C);
    wr_txn(7'h25, 8'h03, 8'h0F, acks);
    rx_txn(7'h25, v, ack);
    chk("R4 receive reg3", {24'd0, v}, 32'h0F);

    // R5: broadcast
    wr_txn(7'h30, 8'h00, 8'h77, acks);
    chk("R5 broadcast write acks", {29'd0, acks}, 32'd7);
    repeat (8) @(negedge clk);
    chk("R5 broadcast reg0", {24'd0, regs[7:0]}, 32'h77);
    rx_txn(7'h30, v, ack);
    chk("R5 broadcast read nack", {31'd0, ack}, 32'd0);

    // R1: foreign address
    wr_txn(7'h26, 8'h00, 8'hEE, acks);
    chk("R1 foreign addr nack", {29'd0, acks}, 32'd0);
    repeat (8) @(negedge clk);
    chk("R1 foreign addr no write", regs, flat_model());

    // R6: alert address without interrupt
    rx_txn(7'h0C, v, ack);
    chk("R6 alert nack without int", {31'd0, ack}, 32'd0);

    // R8: request raised mid-transaction is held off
    start_cond();
    write_byte({7'h25, 1'b0}, ack);
    irq_req = 1'b1;
    last_evt = cyc;
    repeat (12) @(negedge clk);
    chk("R8 int frozen in txn", {31'd0, int_n}, 32'd1);
    write_byte(8'h01, ack);
    write_byte(8'h42, ack);
    mregs[1] = 8'h42;
    stop_cond();
    repeat (8) @(negedge clk);
    chk("R8 int after stop", {31'd0, int_n}, 32'd0);

    // R6: alert response with interrupt asserted
    rx_txn(7'h0C, v, ack);
    chk("R6 alert ack", {31'd0, ack}, 32'd1);
    chk("R6 alert returns own address", {24'd0, v}, 32'h4A);

    // R1: strap change
    strap = 4'b1010;
    last_evt = cyc;
    repeat (8) @(negedge clk);
    wr_txn(7'h25, 8'h00, 8'h11, acks);
    chk("R1 old address nack", {29'd0, acks}, 32'd0);
    wr_txn(7'h2A, 8'h00, 8'h11, acks);
    chk("R1 new address acks", {29'd0, acks}, 32'd7);
    rx_txn(7'h0C, v, ack);
    chk("R6 alert new address", {24'd0, v}, 32'h54);
    irq_req = 1'b0;
    last_evt = cyc;
    repeat (8) @(negedge clk);

    // R7: repeated START abandons a partial write
    start_cond();
    write_byte({7'h2A, 1'b0}, ack);
    write_byte(8'h03, ack);
    start_cond();
    write_byte({7'h2A, 1'b0}, ack);
    chk("R7 address after restart", {31'd0, ack}, 32'd1);
    write_byte(8'h00, ack);
    write_byte(8'h99, ack);
    mregs[0] = 8'h99;
    stop_cond();
    repeat (8) @(negedge clk);
    chk("R7 reg0 after restart", {24'd0, regs[7:0]}, 32'h99);
    chk("R7 reg3 untouched", {24'd0, regs[31:24]}, 32'h0F);
    chk("R10 released after stop", {31'd0, sda_pull}, 32'd0);

    repeat (10) @(negedge clk);
    finish_up();
  end
endmodule